// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter with Pin-Channel Rotation

This block chooses which of four DMA channels may run the next transfer unit. Channels 3 and 2 always rank highest, in that order. Channels 1 and 0 are the two channels driven by external request pins, and they rank below the fixed pair. Their relative order is not fixed. Each time one of them completes a byte or word transfer, that channel drops to the lowest position. A single state bit records which of the two is currently lower. After reset that bit marks channel 0 as lower, so the starting order is 3, 2, 1, 0.

A grant is issued only while no transfer is in progress, and it is held until a completion pulse names the granted channel. A small controller does this with two states. In IDLE, any active request moves it to HOLD and registers a one-hot grant for the winning channel (transition GRANT). In HOLD, a completion pulse whose channel tag equals the granted channel returns it to IDLE (transition RELEASE). In the same clock edge the grant clears and the rotation bit updates. Any other pulse in HOLD leaves the controller in HOLD (transition STAY). In IDLE with no request the controller also stays put (transition WAIT). The next arbitration therefore starts one cycle after a completion and uses the updated order. The current order is available on an output for observation.

Top module: `dma_pin_rr_arbiter`

## Requirements
- R1: After reset is released, `grant` is 4'b0000 and `prio_order` is 8'hE4 (order 3, 2, 1, 0).
- R2: When arbitrating, channel 3 beats every other channel, and channel 2 beats channels 1 and 0. The rotation state never changes this.
- R3: When channels 0 and 1 both request and neither channel 2 nor 3 does, the one of the pair that is currently higher is granted. After reset this is channel 1.
- R4: `grant` is one-hot or zero. It is set on the clock edge after an arbitration in IDLE and then stays unchanged while requests change, until a completion for the granted channel arrives.
- R5: On the clock edge that samples `xfer_done` high with `xfer_ch` equal to the granted channel, `grant` becomes zero and `prio_order` takes its new value. A new grant can appear no earlier than the following edge.
- R6: A completion of channel 0 or 1 makes that channel the lowest of the pair. If it was already lowest, `prio_order` stays the same.
- R7: A completion of a granted channel 2 or 3 ends the grant but leaves `prio_order` unchanged.
- R8: A completion pulse that arrives while nothing is granted, or that names a channel other than the granted one, changes neither `grant` nor `prio_order`.
- R9: With no request active and no grant held, `grant` stays 4'b0000.
- R10: `prio_order` holds four 2-bit channel indices, highest priority in bits [7:6] and lowest in bits [1:0]. The value is 8'hE4 when channel 0 is lower and 8'hE1 when channel 1 is lower.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_lines | input | 4 | Transfer request per channel, bit n for channel n |
| xfer_done | input | 1 | One-cycle pulse: a transfer unit has completed |
| xfer_ch | input | 2 | Channel index that completed, valid with `xfer_done` |
| grant | output | 4 | One-hot grant, bit n for channel n |
| prio_order | output | 8 | Current priority order, four 2-bit indices, highest first |

## Verification
The assertions assume that `xfer_done` is a single-cycle pulse for each finished transfer unit, and that `xfer_ch` is meaningful only in that cycle. They also assume that requests are stable values with no unknowns once reset is released. The stimulus follows these assumptions by changing inputs only on falling clock edges and raising each completion pulse for exactly one cycle. The sequence walks the rotation bit through both values and repeats a completion on a channel that is already lowest. It also sends completion pulses that must be ignored: one naming a channel that is not granted, and one arriving while nothing is granted.

// File: rtl/dmarr_pkg.sv
package dmarr_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } arb_st_t;

endpackage

// File: rtl/dmarr_prio_select.sv
module dmarr_prio_select #(
    parameter int NCH  = 4,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic [NCH-1:0]  req,
    input  logic            low_sel,
    output logic            win_any,
    output logic [CH_W-1:0] win_idx
);

    logic [CH_W-1:0] pair_hi;
    logic [CH_W-1:0] pair_lo;
    logic            fixed_hit;

    // low_sel = 0 means channel 0 is the lower one of the pair
    assign pair_hi = low_sel ? CH_W'(0) : CH_W'(1);
    assign pair_lo = low_sel ? CH_W'(1) : CH_W'(0);

    always_comb begin
        fixed_hit = 1'b0;
        win_idx   = '0;
        // ascending scan: the highest requesting fixed channel wins
        for (int i = 2; i < NCH; i++) begin
            if (req[i]) begin
                fixed_hit = 1'b1;
                win_idx   = CH_W'(i);
            end
        end
        if (!fixed_hit) begin
            if (req[pair_hi])
                win_idx = pair_hi;
            else
                win_idx = pair_lo;
        end
        win_any = |req;
    end

    always_comb begin
        // R2
        if (req[NCH-1] == 1'b1)
            top_fixed_wins_chk: assert (win_idx == CH_W'(NCH-1));
    end

endmodule

// File: rtl/dmarr_rot_state.sv
module dmarr_rot_state #(
    parameter int NCH  = 4,
    parameter int CH_W = $clog2(NCH),
    localparam int ORD_W = NCH * CH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_valid,
    input  logic [CH_W-1:0]  upd_chan,
    output logic             low_sel,
    output logic [ORD_W-1:0] order
);

    logic low_q;
    logic pair_upd;

    assign pair_upd = upd_valid && (upd_chan < CH_W'(2));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_q <= 1'b0;
        else if (pair_upd)
            low_q <= upd_chan[0];
    end

    assign low_sel = low_q;

    // slot p = 0 is the lowest priority; fixed channels sit in the slot of their own index
    generate
        for (genvar p = 0; p < NCH; p++) begin : g_slot
            if (p == 0) begin : g_low
                assign order[p*CH_W +: CH_W] = low_q ? CH_W'(1) : CH_W'(0);
            end else if (p == 1) begin : g_high
                assign order[p*CH_W +: CH_W] = low_q ? CH_W'(0) : CH_W'(1);
            end else begin : g_fixed
                assign order[p*CH_W +: CH_W] = CH_W'(p);
            end
        end
    endgenerate

    // R6
    finisher_goes_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_upd |=> (low_q == $past(upd_chan[0])));

    // R7
    fixed_done_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !pair_upd) |=> $stable(low_q));

    // R8
    no_release_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(low_q));

endmodule

// File: rtl/dmarr_grant_fsm.sv
module dmarr_grant_fsm
    import dmarr_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            win_any,
    input  logic [CH_W-1:0] win_idx,
    input  logic            done_pulse,
    input  logic [CH_W-1:0] done_chan,
    output logic [NCH-1:0]  grant,
    output logic            upd_valid,
    output logic [CH_W-1:0] upd_chan
);

    arb_st_t         state_q, state_d;
    logic [CH_W-1:0] own_q, own_d;
    logic [NCH-1:0]  grant_q, grant_d;
    logic            release_hit;

    assign release_hit = done_pulse && (done_chan == own_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            own_q   <= '0;
            grant_q <= '0;
        end else begin
            state_q <= state_d;
            own_q   <= own_d;
            grant_q <= grant_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        own_d     = own_q;
        grant_d   = grant_q;
        upd_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (win_any) begin
                    state_d          = ST_HOLD;
                    own_d            = win_idx;
                    grant_d          = '0;
                    grant_d[win_idx] = 1'b1;
                end
            end
            ST_HOLD: begin
                if (release_hit) begin
                    state_d   = ST_IDLE;
                    grant_d   = '0;
                    upd_valid = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign grant    = grant_q;
    assign upd_chan = own_q;

    // R4
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_q));

    // R4
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !release_hit) |=> $stable(grant_q));

    // R5
    grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (grant_q == '0));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !win_any) |=> (grant_q == '0));

endmodule

// File: rtl/dma_pin_rr_arbiter.sv
module dma_pin_rr_arbiter #(
    parameter int NCH  = 4,
    parameter int CH_W = $clog2(NCH),
    localparam int ORD_W = NCH * CH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   req_lines,
    input  logic             xfer_done,
    input  logic [CH_W-1:0]  xfer_ch,
    output logic [NCH-1:0]   grant,
    output logic [ORD_W-1:0] prio_order
);

    logic            low_sel;
    logic            win_any;
    logic [CH_W-1:0] win_idx;
    logic            upd_valid;
    logic [CH_W-1:0] upd_chan;

    dmarr_prio_select #(.NCH(NCH), .CH_W(CH_W)) u_sel (
        .req     (req_lines),
        .low_sel (low_sel),
        .win_any (win_any),
        .win_idx (win_idx)
    );

    dmarr_grant_fsm #(.NCH(NCH), .CH_W(CH_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_any    (win_any),
        .win_idx    (win_idx),
        .done_pulse (xfer_done),
        .done_chan  (xfer_ch),
        .grant      (grant),
        .upd_valid  (upd_valid),
        .upd_chan   (upd_chan)
    );

    dmarr_rot_state #(.NCH(NCH), .CH_W(CH_W)) u_rot (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (upd_valid),
        .upd_chan  (upd_chan),
        .low_sel   (low_sel),
        .order     (prio_order)
    );

endmodule

// File: tb/sim_dma_pin_rr_arbiter.sv
module sim_dma_pin_rr_arbiter;

    typedef struct {
        logic [3:0] g;
        logic [7:0] o;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req_lines = 4'b0000;
    logic       xfer_done = 1'b0;
    logic [1:0] xfer_ch = 2'b00;
    logic [3:0] grant;
    logic [7:0] prio_order;

    int   checks = 0;
    int   errors = 0;
    bit   ended = 1'b0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    dma_pin_rr_arbiter u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_lines  (req_lines),
        .xfer_done  (xfer_done),
        .xfer_ch    (xfer_ch),
        .grant      (grant),
        .prio_order (prio_order)
    );

    task automatic compare(input exp_t e);
        checks++;
        if (grant !== e.g || prio_order !== e.o) begin
            errors++;
            $display("FAIL %s grant=%b order=%h expected grant=%b order=%h",
                     e.tag, grant, prio_order, e.g, e.o);
        end
    endtask

    // driver: apply one cycle of stimulus, queue what the following edge must produce
    task automatic cyc(input logic [3:0] r, input logic d, input logic [1:0] c,
                       input logic [3:0] eg, input logic [7:0] eo, input string tag);
        exp_t e;
        @(negedge clk);
        req_lines = r;
        xfer_done = d;
        xfer_ch   = c;
        e.g = eg; e.o = eo; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor: sample shortly after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) compare(sb_q.pop_front());
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        exp_t e;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        e.g = 4'b0000; e.o = 8'hE4; e.tag = "R1 reset state";
        compare(e);

        cyc(4'b0011, 0, 2'd0, 4'b0010, 8'hE4, "R3 pair tie after reset, ch1 first");
        cyc(4'b0011, 0, 2'd0, 4'b0010, 8'hE4, "R4 grant held");
        cyc(4'b1111, 0, 2'd0, 4'b0010, 8'hE4, "R4 held despite higher requests");
        cyc(4'b0011, 1, 2'd0, 4'b0010, 8'hE4, "R8 done for other channel ignored");
        cyc(4'b0011, 1, 2'd1, 4'b0000, 8'hE1, "R5 R6 ch1 done: drop and ch1 lowest");
        cyc(4'b0011, 0, 2'd0, 4'b0001, 8'hE1, "R3 pair tie now ch0 first");
        cyc(4'b0001, 1, 2'd0, 4'b0000, 8'hE4, "R6 R10 ch0 done: ch0 lowest");
        cyc(4'b0001, 0, 2'd0, 4'b0001, 8'hE4, "R3 lone ch0 granted");
        cyc(4'b0001, 1, 2'd0, 4'b0000, 8'hE4, "R6 ch0 already lowest, order kept");
        cyc(4'b0000, 0, 2'd0, 4'b0000, 8'hE4, "R9 no request no grant");
        cyc(4'b0000, 1, 2'd1, 4'b0000, 8'hE4, "R8 done with nothing granted");
        cyc(4'b0000, 0, 2'd0, 4'b0000, 8'hE4, "R8 order untouched after stray done");
        cyc(4'b0110, 0, 2'd0, 4'b0100, 8'hE4, "R2 ch2 beats ch1");
        cyc(4'b0110, 1, 2'd2, 4'b0000, 8'hE4, "R7 ch2 done keeps order");
        cyc(4'b1010, 0, 2'd0, 4'b1000, 8'hE4, "R2 ch3 beats ch1");
        cyc(4'b1010, 1, 2'd3, 4'b0000, 8'hE4, "R7 ch3 done keeps order");
        cyc(4'b0010, 0, 2'd0, 4'b0010, 8'hE4, "R2 lone ch1 granted");
        cyc(4'b0000, 1, 2'd1, 4'b0000, 8'hE1, "R6 R10 ch1 done gives E1");
        cyc(4'b0011, 0, 2'd0, 4'b0001, 8'hE1, "R3 ch0 higher after ch1 done");
        cyc(4'b1000, 1, 2'd3, 4'b0001, 8'hE1, "R8 done for ch3 while ch0 held");
        cyc(4'b0000, 1, 2'd0, 4'b0000, 8'hE4, "R5 R6 ch0 done drop and swap");
        cyc(4'b0000, 0, 2'd0, 4'b0000, 8'hE4, "R9 idle after drop");

        @(negedge clk);
        xfer_done = 1'b0;
        repeat (2) @(posedge clk);
        #3;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule